// File: doc/BRIEF.md
# Polled Status/Data I/O Port

This block sits between a processor and one input device plus one output device. Neither device shares a control line or a clock with the processor. Each direction offers the processor two registers: a status word whose top bit says whether the channel is ready, and a data word. The processor polls the status words through a small synchronous register interface. It moves data only when the matching ready bit allows it.

On the input side, the device places a value on its data lines and raises a strobe. The block synchronises the strobe, captures the value and raises input-ready. Reading the input data register returns the value and drops input-ready. On the output side, output-ready starts set. A processor write to the output data register presents the value to the device and drops output-ready. The device raises its consume strobe once it has taken the value, and that brings output-ready back. A write made while output-ready is low is discarded, and a sticky overrun flag records it.

Register reads are registered: `cpu_rdata` shows the selected word from the clock edge that samples the access. Side effects take place on that same edge. Each device strobe must be a level raised and later lowered. The data that goes with an input strobe must stay stable until input-ready is seen. That is at most four clock edges after the strobe rises.

Top module: `pio_port`

## Requirements
- R1: After reset, input-ready is 0, output-ready is 1, overrun is 0, both data registers and `cpu_rdata` are zero, `dev_in_busy` is 0 and `dev_out_full` is 0.
- R2: Address map: 0 is input status, 1 is input data, 2 is output status, 3 is output data. In a status word, bit 15 is the ready flag. Bit 14 of the output status word is overrun. Every other status bit reads as 0.
- R3: A read of either status register changes no state; repeated reads return the same word.
- R4: A rising edge on `dev_in_stb` captures `dev_in_data` into the input data register and sets input-ready within four clock edges. `dev_in_busy` mirrors input-ready.
- R5: A processor read of address 1 returns the input data and clears input-ready.
- R6: A processor write to address 3 while output-ready is 1 loads the value onto `dev_out_data` and clears output-ready. `dev_out_full` is the inverse of output-ready.
- R7: A rising edge on `dev_out_ack` sets output-ready. A strobe held high counts only once.
- R8: A write to address 3 while output-ready is 0 leaves `dev_out_data` unchanged and sets overrun. Overrun stays set until it is cleared.
- R9: Writing a 1 into bit 14 of address 2 clears overrun. Writing 0 there does nothing, and writes to addresses 0 and 1 change nothing.
- R10: When an input strobe edge coincides with a processor read of address 1, the read returns the old value. Input-ready stays set and the new value is held.
- R11: When a consume edge coincides with a rejected output write, overrun is set and output-ready ends at 1.
- R12: A second input strobe before the processor reads replaces the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Register access in this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |
| dev_in_stb | input | 1 | Input device strobe, asynchronous |
| dev_in_data | input | 16 | Input device data |
| dev_in_busy | output | 1 | Input value not yet read by the processor |
| dev_out_ack | input | 1 | Output device consume strobe, asynchronous |
| dev_out_data | output | 16 | Output data register |
| dev_out_full | output | 1 | Output value waiting for the device |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the synchronised input strobe edge and a processor read of the input data register. The second pair is the consume edge and a write to the output data register. The bench raises a strobe and then issues the processor access exactly two falling edges later, so that the access is sampled on the edge where the synchronised pulse is live. It then judges the outcome through later status and data reads: the read returns the old value while ready stays set with the new value, and the rejected write leaves overrun set with output-ready restored.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        REG_IN_STAT  = 2'd0,
        REG_IN_DATA  = 2'd1,
        REG_OUT_STAT = 2'd2,
        REG_OUT_DATA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rd_in_data;
        logic wr_out_data;
        logic clr_ovr;
        logic rd_any;
    } access_t;

    function automatic access_t decode_access(input logic sel, input logic we,
                                              input logic [1:0] addr,
                                              input logic ovr_bit);
        access_t a;
        reg_sel_e r;
        r             = reg_sel_e'(addr);
        a.rd_any      = sel && !we;
        a.rd_in_data  = sel && !we && (r == REG_IN_DATA);
        a.wr_out_data = sel && we && (r == REG_OUT_DATA);
        a.clr_ovr     = sel && we && (r == REG_OUT_STAT) && ovr_bit;
        return a;
    endfunction

endpackage

// File: rtl/pio_sync_edge.sv
module pio_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign rise_pulse = chain[STAGES-1] & ~last;
endmodule

// File: rtl/pio_in_chan.sv
module pio_in_chan #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_pulse,
    input  logic [DATA_W-1:0] load_data,
    input  logic              cpu_take,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ready_q <= 1'b0;
        end else if (load_pulse) begin
            data_q  <= load_data;
            ready_q <= 1'b1;
        end else if (cpu_take) begin
            ready_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pio_out_chan.sv
module pio_out_chan #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              consume_pulse,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q,
    output logic              ovr_q
);
    logic accept, reject;

    assign accept = wr_req & ready_q;
    assign reject = wr_req & ~ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ready_q <= 1'b1;
        end else if (accept) begin
            data_q  <= wr_data;
            ready_q <= 1'b0;
        end else if (consume_pulse) begin
            ready_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ovr_q <= 1'b0;
        else if (reject)  ovr_q <= 1'b1;
        else if (ovr_clr) ovr_q <= 1'b0;
    end
endmodule

// File: rtl/pio_regif.sv
module pio_regif
    import pio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic              wbit_ovr,
    input  logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_ready,
    input  logic              out_ovr,
    output access_t           acc,
    output logic [DATA_W-1:0] rdata
);
    localparam int RDY_POS = DATA_W - 1;
    localparam int OVR_POS = DATA_W - 2;

    logic [DATA_W-1:0] in_stat, out_stat, rd_mux;

    assign acc = decode_access(sel, we, addr, wbit_ovr);

    always_comb begin
        in_stat           = '0;
        in_stat[RDY_POS]  = in_ready;
        out_stat          = '0;
        out_stat[RDY_POS] = out_ready;
        out_stat[OVR_POS] = out_ovr;
        unique case (reg_sel_e'(addr))
            REG_IN_STAT:  rd_mux = in_stat;
            REG_IN_DATA:  rd_mux = in_data;
            REG_OUT_STAT: rd_mux = out_stat;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)             rdata <= '0;
        else if (acc.rd_any) rdata <= rd_mux;
    end
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int DATA_W      = WORD_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dev_in_stb,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_busy,
    input  logic              dev_out_ack,
    output logic [DATA_W-1:0] dev_out_data,
    output logic              dev_out_full
);
    localparam int OVR_POS = DATA_W - 2;

    logic              in_pulse, out_pulse;
    logic              in_ready, out_ready, out_ovr;
    logic [DATA_W-1:0] in_data, out_data;
    access_t           acc;

    pio_sync_edge #(.STAGES(SYNC_STAGES)) u_in_sync (
        .clk(clk), .rst(rst), .async_in(dev_in_stb), .rise_pulse(in_pulse));

    pio_sync_edge #(.STAGES(SYNC_STAGES)) u_out_sync (
        .clk(clk), .rst(rst), .async_in(dev_out_ack), .rise_pulse(out_pulse));

    pio_in_chan #(.DATA_W(DATA_W)) u_in (
        .clk(clk), .rst(rst), .load_pulse(in_pulse), .load_data(dev_in_data),
        .cpu_take(acc.rd_in_data), .data_q(in_data), .ready_q(in_ready));

    pio_out_chan #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .wr_req(acc.wr_out_data), .wr_data(cpu_wdata),
        .consume_pulse(out_pulse), .ovr_clr(acc.clr_ovr),
        .data_q(out_data), .ready_q(out_ready), .ovr_q(out_ovr));

    pio_regif #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .sel(cpu_sel), .we(cpu_we), .addr(cpu_addr),
        .wbit_ovr(cpu_wdata[OVR_POS]), .in_ready(in_ready), .in_data(in_data),
        .out_ready(out_ready), .out_ovr(out_ovr), .acc(acc), .rdata(cpu_rdata));

    assign dev_in_busy  = in_ready;
    assign dev_out_full = ~out_ready;
    assign dev_out_data = out_data;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sel,
    input logic              we,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] dev_in_data,
    input logic              in_pulse,
    input logic              out_pulse,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              ovr
);
    p_in_stat_layout_r2: assert property (@(posedge clk) disable iff (rst)
        (sel && !we && addr == 2'd0) |=>
            (rdata[DATA_W-2:0] == '0) && (rdata[DATA_W-1] == $past(in_ready)));

    p_stat_read_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (sel && !we && !addr[0] && !in_pulse && !out_pulse) |=>
            $stable(in_ready) && $stable(out_ready) && $stable(ovr));

    p_in_capture_r4: assert property (@(posedge clk) disable iff (rst)
        in_pulse |=> in_ready && (in_data == $past(dev_in_data)));

    p_in_take_r5: assert property (@(posedge clk) disable iff (rst)
        (sel && !we && addr == 2'd1 && !in_pulse) |=> !in_ready);

    p_out_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (sel && we && addr == 2'd3 && out_ready) |=>
            !out_ready && (out_data == $past(wdata)));

    p_consume_r7: assert property (@(posedge clk) disable iff (rst)
        (out_pulse && !(sel && we && addr == 2'd3 && out_ready)) |=> out_ready);

    p_consume_once_r7: assert property (@(posedge clk) disable iff (rst)
        out_pulse |=> !out_pulse);

    p_out_reject_r8: assert property (@(posedge clk) disable iff (rst)
        (sel && we && addr == 2'd3 && !out_ready) |=> ovr && $stable(out_data));

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovr && !(sel && we && addr == 2'd2 && wdata[DATA_W-2])) |=> ovr);
endmodule

bind pio_port pio_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .sel(cpu_sel), .we(cpu_we), .addr(cpu_addr),
    .wdata(cpu_wdata), .rdata(cpu_rdata), .dev_in_data(dev_in_data),
    .in_pulse(in_pulse), .out_pulse(out_pulse), .in_ready(in_ready),
    .in_data(in_data), .out_ready(out_ready), .out_data(out_data), .ovr(out_ovr));

// File: tb/tb_pio_port.sv
module tb_pio_port;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [1:0]   cpu_addr = '0;
    logic [W-1:0] cpu_wdata = '0, cpu_rdata;
    logic         dev_in_stb = 1'b0, dev_out_ack = 1'b0;
    logic [W-1:0] dev_in_data = '0, dev_out_data;
    logic         dev_in_busy, dev_out_full;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    logic         rd_issued = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_port dut (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dev_in_stb(dev_in_stb), .dev_in_data(dev_in_data),
        .dev_in_busy(dev_in_busy), .dev_out_ack(dev_out_ack),
        .dev_out_data(dev_out_data), .dev_out_full(dev_out_full));

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                         input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares each registered read against the scoreboard
    always @(posedge clk) rd_issued <= cpu_sel && !cpu_we;
    always @(negedge clk) begin
        if (rd_issued) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard: read with no expectation, actual %h expected none",
                         cpu_rdata);
            end else begin
                check(cpu_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // driver tasks are called just after a falling edge
    task automatic cpu_read(input logic [1:0] a, input logic [W-1:0] exp,
                            input string tag);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [W-1:0] d);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dev_put(input logic [W-1:0] d);
        dev_in_data = d; dev_in_stb = 1'b1;
        idle(6);
        dev_in_stb = 1'b0;
        idle(4);
    endtask

    task automatic dev_consume();
        dev_out_ack = 1'b1;
        idle(6);
        dev_out_ack = 1'b0;
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        check({15'd0, dev_in_busy}, 16'd0, "R1 in_busy");
        check({15'd0, dev_out_full}, 16'd0, "R1 out_full");
        check(dev_out_data, 16'd0, "R1 out_data");
        check(cpu_rdata, 16'd0, "R1 rdata");
        cpu_read(2'd0, 16'h0000, "R1 in_stat");
        cpu_read(2'd2, 16'h8000, "R1/R2 out_stat");
        cpu_read(2'd1, 16'h0000, "R1 in_data");

        // R4 capture, R3 quiet status, R5 read clears
        dev_put(16'h1234);
        check({15'd0, dev_in_busy}, 16'd1, "R4 busy");
        cpu_read(2'd0, 16'h8000, "R4/R2 in_stat");
        cpu_read(2'd0, 16'h8000, "R3 repeat status");
        cpu_read(2'd1, 16'h1234, "R5 in_data");
        cpu_read(2'd0, 16'h0000, "R5 ready cleared");
        check({15'd0, dev_in_busy}, 16'd0, "R5 busy");

        // R12 overwrite before read
        dev_put(16'hAAAA);
        dev_put(16'h5555);
        cpu_read(2'd1, 16'h5555, "R12 newest kept");

        // R6 accepted write
        cpu_write(2'd3, 16'hBEEF);
        check(dev_out_data, 16'hBEEF, "R6 out_data");
        check({15'd0, dev_out_full}, 16'd1, "R6 full");
        cpu_read(2'd2, 16'h0000, "R6 out_stat");

        // R8 rejected write
        cpu_write(2'd3, 16'h1111);
        check(dev_out_data, 16'hBEEF, "R8 data unchanged");
        cpu_read(2'd2, 16'h4000, "R8 overrun");
        idle(3);
        cpu_read(2'd2, 16'h4000, "R8 sticky");

        // R9 clear rules
        cpu_write(2'd0, 16'hFFFF);
        cpu_write(2'd1, 16'hFFFF);
        cpu_read(2'd2, 16'h4000, "R9 other writes ignored");
        cpu_read(2'd0, 16'h0000, "R9 in_stat untouched");
        cpu_write(2'd2, 16'h0000);
        cpu_read(2'd2, 16'h4000, "R9 zero write");
        cpu_write(2'd2, 16'h4000);
        cpu_read(2'd2, 16'h0000, "R9 cleared");

        // R7 consume, held strobe counts once
        dev_out_ack = 1'b1;
        idle(5);
        cpu_read(2'd2, 16'h8000, "R7 ready set");
        cpu_write(2'd3, 16'h3333);
        idle(4);
        cpu_read(2'd2, 16'h0000, "R7 held strobe once");
        check(dev_out_data, 16'h3333, "R7 out_data");
        dev_out_ack = 1'b0;
        idle(4);
        dev_consume();
        cpu_read(2'd2, 16'h8000, "R7 second edge");

        // R10 strobe edge meets data read
        dev_put(16'h0A0A);
        dev_in_data = 16'h0B0B; dev_in_stb = 1'b1;
        idle(2);
        cpu_read(2'd1, 16'h0A0A, "R10 old value");
        idle(3);
        dev_in_stb = 1'b0;
        cpu_read(2'd0, 16'h8000, "R10 ready kept");
        cpu_read(2'd1, 16'h0B0B, "R10 new value");

        // R11 consume edge meets rejected write
        cpu_write(2'd3, 16'h4444);
        dev_out_ack = 1'b1;
        idle(2);
        cpu_write(2'd3, 16'h5555);
        idle(3);
        dev_out_ack = 1'b0;
        cpu_read(2'd2, 16'hC000, "R11 ready and overrun");
        check(dev_out_data, 16'h4444, "R11 data kept");

        idle(3);
        check(exp_q.size(), 16'd0, "scoreboard drained");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule